// File: doc/BRIEF.md
# Ones' complement adder-subtractor

This block adds or subtracts two signed words held in ones' complement form. In that form a negative value is the bit-by-bit inverse of its magnitude: with eight bits, +5 is `0000_0101` and -5 is `1111_1010`. Subtraction uses the same adder as addition. When `sub` is high, every bit of the second operand is inverted before it reaches the adder.

A carry out of the top bit of the first addition is not discarded. It is added back into the bottom bit in the same cycle, and any carries that this creates ripple upward as usual. The block then produces four flags. The overflow flag is computed from the operand and result sign bits. The zero flag recognises both encodings of zero. A separate flag marks the all-ones (negative zero) pattern. The raw carry of the first addition is also brought out.

Operands are accepted when `in_valid` is high. The result and flags appear on registered outputs one clock later, with `out_valid`. The parameter `NORMALIZE_ZERO` can be set so that the all-ones result is delivered as all-zeros.

Top module: `oc_addsub`

## Requirements
- R1: With `sub` low, `sum` is A+B with the end-around carry applied. Taking M = 2^WIDTH-1, the result pattern equals (A+B) mod M, and a result worth zero is all-ones unless both addends are all-zeros. The result and flags appear one clock after the cycle in which `in_valid` is high.
- R2: With `sub` high, the second addend is the bitwise inverse of `b`, so the result is A minus B under the same rules as R1. For example, 4-bit 0101 minus 0111 gives 1101.
- R3: `carry_out` is the carry out of bit WIDTH-1 of the first, uncorrected addition of A and the possibly inverted B. For example, 4-bit 0010+1110 gives `carry_out`=1 and `sum`=0001.
- R4: `overflow` is high exactly when the true signed result lies outside -(2^(WIDTH-1)-1)..+(2^(WIDTH-1)-1). This is the case where both addends share a sign bit and the uncorrected-for-zero result sign differs from it.
- R5: `zero` is high when the computed result is all-zeros or all-ones.
- R6: `neg_zero` is high when the computed result, before any zero normalisation, is all-ones.
- R7: With `NORMALIZE_ZERO`=1, an all-ones result is output as all-zeros, while `zero` and `neg_zero` still report it. With `NORMALIZE_ZERO`=0 the pattern passes through unchanged.
- R8: `out_valid` equals `in_valid` of the previous cycle. In a cycle after `in_valid` was low, `sum` and the flags keep their previous values.
- R9: A synchronous active-low reset (`rst_n`=0) clears `out_valid`, `sum` and all four flags on the next clock edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| a | input | WIDTH | First operand, ones' complement |
| b | input | WIDTH | Second operand, ones' complement |
| sub | input | 1 | 1: subtract `b`, 0: add `b` |
| out_valid | output | 1 | Registered result is fresh |
| sum | output | WIDTH | Registered result |
| overflow | output | 1 | Signed result out of range |
| zero | output | 1 | Result is either zero encoding |
| neg_zero | output | 1 | Result was the all-ones pattern |
| carry_out | output | 1 | Carry out of the first addition |

## Verification
The bench builds two copies of the block.

The first has WIDTH=4 and NORMALIZE_ZERO=0. At that width every operand pair can be tried under both add and subtract. This covers every end-around carry case, both zero encodings, every overflow boundary at ±7, and the double-negative-zero sum, each compared with an integer model.

The second has WIDTH=16 and NORMALIZE_ZERO=1. It takes random operands and directed negative-zero cases. These exercise the wide carry ripple after the end-around correction and the replacement of the all-ones pattern.

// File: rtl/oc_pkg.sv
// Package: shared flag bundle for the ones' complement adder-subtractor.
// Assumes: one flag set accompanies every result word.
package oc_pkg;

    // Status that travels with each result
    typedef struct packed {
        logic overflow;   // signed result outside representable range
        logic zero;       // result is +0 or -0
        logic neg_zero;   // result pattern was all ones
        logic carry;      // carry out of the first addition
    } oc_flags_t;

    localparam oc_flags_t OC_FLAGS_CLEAR = '{overflow: 1'b0, zero: 1'b0,
                                             neg_zero: 1'b0, carry: 1'b0};

endpackage

// File: rtl/oc_operand_prep.sv
// Module: oc_operand_prep
// Inverts every bit of the second operand when a subtraction is requested.
// Assumes: operands are ones' complement, so inversion is exact negation.
module oc_operand_prep #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic             sub,
    output logic [WIDTH-1:0] b_out
);

    // One XOR per bit: conditional complement
    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign b_out[i] = b_in[i] ^ sub;
    end

endmodule

// File: rtl/oc_eac_adder.sv
// Module: oc_eac_adder
// Adds two words and folds the carry from the top bit back into the bottom bit,
// all combinationally in one pass.
// Assumes: both inputs are WIDTH-bit ones' complement words.
module oc_eac_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] sum,
    output logic             first_carry,
    output logic             second_carry
);

    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] first_pass;
    logic [EXT-1:0] second_pass;

    // First addition, keeping the carry out of the top bit
    always_comb begin
        first_pass = {1'b0, x} + {1'b0, y};
    end

    // End-around correction: add the carry into bit 0 and let it ripple
    always_comb begin
        second_pass = {1'b0, first_pass[WIDTH-1:0]} + EXT'(first_pass[WIDTH]);
    end

    assign first_carry  = first_pass[WIDTH];
    assign second_carry = second_pass[WIDTH];
    assign sum          = second_pass[WIDTH-1:0];

endmodule

// File: rtl/oc_flag_gen.sv
// Module: oc_flag_gen
// Derives overflow, zero and negative-zero status from the corrected sum and
// optionally replaces the all-ones pattern by all-zeros.
// Assumes: a_msb and b_msb are the sign bits of the words actually added.
module oc_flag_gen
    import oc_pkg::*;
#(
    parameter int WIDTH          = 8,
    parameter bit NORMALIZE_ZERO = 1'b0
) (
    input  logic             a_msb,
    input  logic             b_msb,
    input  logic [WIDTH-1:0] sum_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output oc_flags_t        flags
);

    localparam int MSB = WIDTH - 1;

    logic is_ones;
    logic is_zeros;

    // Detect the two zero encodings
    always_comb begin
        is_ones  = &sum_in;
        is_zeros = ~|sum_in;
    end

    // Collect flags; overflow uses the sign of the un-normalised sum
    always_comb begin
        flags.overflow = (a_msb == b_msb) && (sum_in[MSB] != a_msb);
        flags.zero     = is_ones | is_zeros;
        flags.neg_zero = is_ones;
        flags.carry    = carry_in;
    end

    // Parameter selects pass-through or normalisation of negative zero
    if (NORMALIZE_ZERO) begin : g_norm
        assign sum_out = is_ones ? '0 : sum_in;
    end else begin : g_raw
        assign sum_out = sum_in;
    end

endmodule

// File: rtl/oc_addsub.sv
// Module: oc_addsub (top)
// Registered ones' complement adder-subtractor with end-around carry and
// a one-cycle valid pipeline.
// Assumes: synchronous active-low reset; operands sampled when in_valid is high.
module oc_addsub
    import oc_pkg::*;
#(
    parameter int WIDTH          = 8,
    parameter bit NORMALIZE_ZERO = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic             out_valid,
    output logic [WIDTH-1:0] sum,
    output logic             overflow,
    output logic             zero,
    output logic             neg_zero,
    output logic             carry_out
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] raw_sum;
    logic [WIDTH-1:0] sum_d;
    logic             c_first;
    logic             c_second;
    oc_flags_t        flags_d;
    oc_flags_t        flags_q;
    logic [WIDTH-1:0] sum_q;
    logic             valid_q;

    oc_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .b_in  (b),
        .sub   (sub),
        .b_out (b_eff)
    );

    oc_eac_adder #(.WIDTH(WIDTH)) u_add (
        .x            (a),
        .y            (b_eff),
        .sum          (raw_sum),
        .first_carry  (c_first),
        .second_carry (c_second)
    );

    oc_flag_gen #(.WIDTH(WIDTH), .NORMALIZE_ZERO(NORMALIZE_ZERO)) u_flags (
        .a_msb    (a[MSB]),
        .b_msb    (b_eff[MSB]),
        .sum_in   (raw_sum),
        .carry_in (c_first),
        .sum_out  (sum_d),
        .flags    (flags_d)
    );

    // Valid pipeline stage
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= in_valid;
    end

    // Result and flag registers, loaded only with fresh operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            flags_q <= OC_FLAGS_CLEAR;
        end else if (in_valid) begin
            sum_q   <= sum_d;
            flags_q <= flags_d;
        end
    end

    assign out_valid = valid_q;
    assign sum       = sum_q;
    assign overflow  = flags_q.overflow;
    assign zero      = flags_q.zero;
    assign neg_zero  = flags_q.neg_zero;
    assign carry_out = flags_q.carry;

    // R1
    eac_single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !c_second);

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(sum) && $stable(zero) && $stable(overflow)));

    // R4
    ovf_not_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> !zero);

    // R6
    negzero_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        neg_zero |-> zero);

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && !overflow && !zero && !neg_zero && !carry_out && sum == '0));

    if (NORMALIZE_ZERO) begin : g_norm_chk
        // R7
        norm_no_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (sum != '1));
    end

endmodule

// File: tb/tb_oc_addsub.sv
`timescale 1ns/1ps
module tb_oc_addsub;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;

    logic        v4, s4;
    logic [3:0]  a4, b4;
    logic        ov4;
    logic [3:0]  o4;
    logic        ovf4, z4, nz4, c4;

    logic        v16, s16;
    logic [15:0] a16, b16;
    logic        ov16;
    logic [15:0] o16;
    logic        ovf16, z16, nz16, c16;

    oc_addsub #(.WIDTH(4), .NORMALIZE_ZERO(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(v4), .a(a4), .b(b4), .sub(s4),
        .out_valid(ov4), .sum(o4), .overflow(ovf4), .zero(z4),
        .neg_zero(nz4), .carry_out(c4));

    oc_addsub #(.WIDTH(16), .NORMALIZE_ZERO(1'b1)) dut_w16 (
        .clk(clk), .rst_n(rst_n), .in_valid(v16), .a(a16), .b(b16), .sub(s16),
        .out_valid(ov16), .sum(o16), .overflow(ovf16), .zero(z16),
        .neg_zero(nz16), .carry_out(c16));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint decode(input longint x, input int n);
        longint m = (longint'(1) << n) - 1;
        if (((x >> (n - 1)) & 1) != 0) return -((~x) & m);
        return x;
    endfunction

    // Integer reference: value, range, re-encoding, zero choice
    task automatic model(input int n, input longint a, input longint b, input bit sub,
                         input bit norm, output longint s, output bit ovf,
                         output bit cy, output bit z, output bit nz);
        longint m    = (longint'(1) << n) - 1;
        longint beff = sub ? ((~b) & m) : b;
        longint tv   = decode(a, n) + decode(beff, n);
        longint maxv = (longint'(1) << (n - 1)) - 1;
        longint r    = ((tv % m) + m) % m;
        if (r == 0) r = (a == 0 && beff == 0) ? 0 : m;
        ovf = (tv > maxv) || (tv < -maxv);
        cy  = (a + beff) > m;
        nz  = (r == m);
        z   = (r == 0) || (r == m);
        s   = (norm && nz) ? 0 : r;
    endtask

    task automatic run4(input int a, input int b, input bit sub, input string req);
        longint es; bit eo, ec, ez, en;
        @(negedge clk); v4 = 1'b1; a4 = 4'(a); b4 = 4'(b); s4 = sub;
        @(negedge clk); v4 = 1'b0;
        model(4, longint'(a), longint'(b), sub, 1'b0, es, eo, ec, ez, en);
        chk(req, "valid", longint'(ov4), 1);
        chk(req, "sum", longint'(o4), es);
        chk(req, "overflow", longint'(ovf4), longint'(eo));
        chk(req, "carry", longint'(c4), longint'(ec));
        chk(req, "zero", longint'(z4), longint'(ez));
        chk(req, "neg_zero", longint'(nz4), longint'(en));
    endtask

    task automatic run16(input int a, input int b, input bit sub, input string req);
        longint es; bit eo, ec, ez, en;
        @(negedge clk); v16 = 1'b1; a16 = 16'(a); b16 = 16'(b); s16 = sub;
        @(negedge clk); v16 = 1'b0;
        model(16, longint'(a), longint'(b), sub, 1'b1, es, eo, ec, ez, en);
        chk(req, "valid16", longint'(ov16), 1);
        chk(req, "sum16", longint'(o16), es);
        chk(req, "overflow16", longint'(ovf16), longint'(eo));
        chk(req, "carry16", longint'(c16), longint'(ec));
        chk(req, "zero16", longint'(z16), longint'(ez));
        chk(req, "neg_zero16", longint'(nz16), longint'(en));
    endtask

    // R9: outputs cleared while reset is held, even with valid operands
    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0; v4 = 1'b1; a4 = 4'd7; b4 = 4'd7; s4 = 1'b0;
        v16 = 1'b1; a16 = 16'hFFFF; b16 = 16'hFFFF; s16 = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9", "valid", longint'(ov4), 0);
        chk("R9", "sum", longint'(o4), 0);
        chk("R9", "flags", longint'({ovf4, z4, nz4, c4}), 0);
        chk("R9", "valid16", longint'(ov16), 0);
        chk("R9", "flags16", longint'({ovf16, z16, nz16, c16}), 0);
        v4 = 1'b0; v16 = 1'b0; rst_n = 1'b1;
    endtask

    // R1 R3: worked end-around example 0010 + 1110 -> 0001, carry 1
    task automatic t_eac_example();
        run4(2, 14, 1'b0, "R1");
        chk("R3", "example carry", longint'(c4), 1);
        chk("R1", "example sum", longint'(o4), 1);
    endtask

    // R2 R5 R6: x - x gives negative zero; 0101 - 0111 gives 1101
    task automatic t_sub_examples();
        run4(5, 5, 1'b1, "R2");
        chk("R6", "5-5 neg_zero", longint'(nz4), 1);
        chk("R5", "5-5 zero", longint'(z4), 1);
        chk("R5", "5-5 pattern", longint'(o4), 15);
        run4(5, 7, 1'b1, "R2");
        chk("R2", "5-7 pattern", longint'(o4), 13);
    endtask

    // R4: range edges +7+1 and -7-1
    task automatic t_overflow();
        run4(7, 1, 1'b0, "R4");
        chk("R4", "+7+1", longint'(ovf4), 1);
        run4(8, 14, 1'b0, "R4");
        chk("R4", "-7-1", longint'(ovf4), 1);
        run4(7, 15, 1'b0, "R4");
        chk("R4", "+7-0", longint'(ovf4), 0);
    endtask

    // R1..R6: every operand pair, both operations, at 4 bits
    task automatic t_exhaustive4();
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run4(a, b, s[0], "R1_R6");
    endtask

    // R8: no new operands means out_valid low and results held
    task automatic t_hold();
        run4(3, 2, 1'b0, "R8");
        @(negedge clk); a4 = 4'd9; b4 = 4'd1; s4 = 1'b1; v4 = 1'b0;
        @(negedge clk);
        chk("R8", "valid low", longint'(ov4), 0);
        chk("R8", "sum held", longint'(o4), 5);
        chk("R8", "zero held", longint'(z4), 0);
    endtask

    // R7: normalised negative zero at 16 bits
    task automatic t_normalize();
        run16(16'h1234, 16'h1234, 1'b1, "R7");
        chk("R7", "norm sum", longint'(o16), 0);
        chk("R7", "norm neg_zero", longint'(nz16), 1);
        run16(16'hFFFF, 16'hFFFF, 1'b0, "R7");
        chk("R7", "-0+-0 sum", longint'(o16), 0);
        run16(0, 0, 1'b0, "R7");
        chk("R7", "+0+0 neg_zero", longint'(nz16), 0);
    endtask

    // R1..R7: random wide operands
    task automatic t_random16();
        for (int i = 0; i < 3000; i++)
            run16(int'($urandom() & 32'hFFFF), int'($urandom() & 32'hFFFF),
                  1'($urandom()), "R1_R7");
    endtask

    // R9: reset after activity clears the registers
    task automatic t_reset_again();
        run4(6, 6, 1'b0, "R9");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R9", "late valid", longint'(ov4), 0);
        chk("R9", "late sum", longint'(o4), 0);
        chk("R9", "late flags", longint'({ovf4, z4, nz4, c4}), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; v4 = 1'b0; a4 = '0; b4 = '0; s4 = 1'b0;
        v16 = 1'b0; a16 = '0; b16 = '0; s16 = 1'b0;
        t_reset();
        t_eac_example();
        t_sub_examples();
        t_overflow();
        t_exhaustive4();
        t_hold();
        t_normalize();
        t_random16();
        t_reset_again();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule